// File: doc/BRIEF.md
# Reset and Instruction-Cycle Clock Controller

This block sits between the active-low external reset pin of a small microcontroller and its core. It turns the input clock into a one-clock instruction-cycle enable that fires on every tenth clock. A low level on the reset pin takes effect at once. The port-control outputs switch to their reset state and the core run signal drops with no clock edge involved. The end of reset follows a different path. It passes through a two-flop synchronizer and a release sequencer, so the core starts running exactly on an instruction-cycle boundary and well inside two instruction cycles of the pin going high.

The block also covers the rest of the reset-entry work. When a reset arrives it ends HALT. It supplies the load values for the stack pointer, the cleared control/status group and the serial-port enable register. It records whether the reset was cold (power-on flag high) or warm. It also flags a write to retained storage that the reset cut short. When the cold flag or the abort flag is set, the core must treat pointer registers, retained prescalers and RAM as undefined.

Top module: `mcu_reset_ctrl`

## Requirements
- R1: While the core is released and not halted, `cyc_en` is a single-clock pulse repeating every 10 clocks. The divider is held at count 0 during reset and restarts from 0 once the synchronized release is seen.
- R2: A low level on `rst_pin_n` forces `port_hiz` and `port_d_high` to 1 and `core_run` to 0 at once, without any clock edge.
- R3: Count the first rising clock edge after `rst_pin_n` goes high as edge 1. `cyc_en` is high after edge 11, and `core_run` rises at edge 12, which is an instruction-cycle boundary. Both fall within two instruction cycles (20 clocks).
- R4: A low pulse on `rst_pin_n` of 10 or more clocks always gives a complete reset followed by the release timing of R3, at any divider phase when the pulse starts.
- R5: If `halt_req` is high at an edge where `cyc_en` is high and the core is running, `halted` goes to 1 and `cyc_en` stays 0. A reset pulse clears `halted`, and release then follows R3.
- R6: `port_hiz` (ports that float) and `port_d_high` (the port driven high) stay 1 through reset until `core_run` rises. Both are 0 while the core runs.
- R7: The reset load values are constant: `sp_rst_val` = 0x6F, `ctrl_rst_val` = 0x00, and `uart_en_rst_val` = 0x02 (only bit 1, the transmit-buffer-empty bit, set).
- R8: On the first clock edge of a warm reset that interrupts a running core, `wr_abort` takes the value of `wr_busy`. It then holds that value through reset and the next run, until the next reset entry.
- R9: At every clock edge inside reset, `cold_rst` takes the value of `por_flag`. A cold reset also clears `wr_abort`. `retained_ok` is 1 exactly when `cold_rst` and `wr_abort` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock, divided by 10 |
| rst_pin_n | input | 1 | External reset pin, active low |
| por_flag | input | 1 | High when the present reset is a power-on (cold) reset |
| halt_req | input | 1 | Core request to enter HALT |
| wr_busy | input | 1 | Core is writing to retained register or RAM |
| cyc_en | output | 1 | Instruction-cycle enable pulse |
| core_run | output | 1 | Core released and allowed to execute |
| halted | output | 1 | Device is in HALT |
| port_hiz | output | 1 | Force floating ports to high impedance |
| port_d_high | output | 1 | Force the high-driven port to 1 |
| wr_abort | output | 1 | Last reset cut a retained write short |
| cold_rst | output | 1 | Last reset was cold |
| retained_ok | output | 1 | Retained storage contents are valid |
| sp_rst_val | output | 8 | Stack pointer load value |
| ctrl_rst_val | output | 8 | Control/status register load value |
| uart_en_rst_val | output | 8 | Serial-port enable register load value |

## Verification
The port forcing and the run drop are combinational in the pin, so the bench checks them 1 ns after it lowers the pin, before any edge. The bench drives the pin 2 ns after a rising edge and counts edges from the release. It expects `cyc_en` after edge 11, `core_run` after edge 12, and then every tenth edge for the cycle pulse. The abort and cold flags are registered on the first edge inside reset, so the bench samples them after that edge. Every sample is taken 2 ns after a rising edge. The pulse-phase sweep repeats the release-count checks for each of the ten divider phases.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef logic [7:0] reg8_t;

  // Load value of a register whose only set bit after reset is at position idx
  function automatic reg8_t single_bit(input int unsigned idx);
    reg8_t v;
    v = '0;
    v[idx[2:0]] = 1'b1;
    return v;
  endfunction

  // Clocks from the first edge after pin release to core run
  function automatic int unsigned release_latency(input int unsigned stages,
                                                   input int unsigned div,
                                                   input int unsigned boundaries);
    return stages + div * boundaries;
  endfunction
endpackage

// File: rtl/rcc_rstsync.sv
module rcc_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic pin_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge pin_n)
        if (!pin_n) chain <= '0;
        else        chain <= 1'b1;
    end else begin : g_multi
      always_ff @(posedge clk or negedge pin_n)
        if (!pin_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], 1'b1};
    end
  endgenerate

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/rcc_cycdiv.sv
module rcc_cycdiv #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic clr,
  input  logic hold,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (clr)        cnt <= '0;
    else if (!hold) cnt <= next_cnt(cnt);

  assign tick = (cnt == LAST) && !clr;

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (clr)
    tick |=> !tick) else $error("cycle tick repeated"); // R1
endmodule

// File: rtl/rcc_relseq.sv
module rcc_relseq #(
  parameter int unsigned BOUNDARIES = 1
) (
  input  logic clk,
  input  logic sync_n,
  input  logic cyc_en,
  output logic run_q
);
  logic fire;

  generate
    if (BOUNDARIES <= 1) begin : g_direct
      assign fire = cyc_en;
    end else begin : g_count
      localparam int unsigned BW = $clog2(BOUNDARIES);
      logic [BW-1:0] seen;
      always_ff @(posedge clk)
        if (!sync_n)     seen <= '0;
        else if (cyc_en && !run_q) seen <= seen + 1'b1;
      assign fire = cyc_en && (seen == BW'(BOUNDARIES - 1));
    end
  endgenerate

  always_ff @(posedge clk)
    if (!sync_n)              run_q <= 1'b0;
    else if (fire && !run_q)  run_q <= 1'b1;

  AST_RUN_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!sync_n)
    $rose(run_q) |-> $past(cyc_en)) else $error("run not on boundary"); // R3
endmodule

// File: rtl/mcu_reset_ctrl.sv
module mcu_reset_ctrl #(
  parameter int unsigned DIV          = 10,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned REL_BOUNDS   = 1,
  parameter logic [7:0]  SP_INIT      = 8'h6F,
  parameter int unsigned TX_EMPTY_BIT = 1
) (
  input  logic       clk_in,
  input  logic       rst_pin_n,
  input  logic       por_flag,
  input  logic       halt_req,
  input  logic       wr_busy,
  output logic       cyc_en,
  output logic       core_run,
  output logic       halted,
  output logic       port_hiz,
  output logic       port_d_high,
  output logic       wr_abort,
  output logic       cold_rst,
  output logic       retained_ok,
  output logic [7:0] sp_rst_val,
  output logic [7:0] ctrl_rst_val,
  output logic [7:0] uart_en_rst_val
);
  import rcc_pkg::*;

  localparam int unsigned REL_LAT = release_latency(SYNC_STAGES, DIV, REL_BOUNDS);

  // Named internal events
  logic sync_n;
  logic run_q;
  logic halted_q;
  logic abort_q;
  logic cold_q;
  logic reset_entry;
  logic halt_take;

  rcc_rstsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk_in),
    .pin_n  (rst_pin_n),
    .sync_n (sync_n)
  );

  rcc_cycdiv #(.DIV(DIV)) u_div (
    .clk  (clk_in),
    .clr  (!sync_n),
    .hold (halted_q),
    .tick (cyc_en)
  );

  rcc_relseq #(.BOUNDARIES(REL_BOUNDS)) u_rel (
    .clk    (clk_in),
    .sync_n (sync_n),
    .cyc_en (cyc_en),
    .run_q  (run_q)
  );

  assign reset_entry = run_q && !sync_n;
  assign halt_take   = cyc_en && run_q && halt_req;

  always_ff @(posedge clk_in)
    if (!sync_n)        halted_q <= 1'b0;
    else if (halt_take) halted_q <= 1'b1;

  always_ff @(posedge clk_in)
    if (!sync_n && por_flag) abort_q <= 1'b0;
    else if (reset_entry)    abort_q <= wr_busy;

  always_ff @(posedge clk_in)
    if (!sync_n) cold_q <= por_flag;

  // Pin path stays combinational; release path is synchronized
  assign core_run    = run_q && rst_pin_n;
  assign port_hiz    = !core_run;
  assign port_d_high = !core_run;
  assign halted      = halted_q;
  assign wr_abort    = abort_q;
  assign cold_rst    = cold_q;
  assign retained_ok = !cold_q && !abort_q;

  assign sp_rst_val      = SP_INIT;
  assign ctrl_rst_val    = '0;
  assign uart_en_rst_val = single_bit(TX_EMPTY_BIT);

  AST_HALT_STOPS_CYCLE: assert property (@(posedge clk_in) disable iff (!sync_n)
    halted_q |-> !cyc_en) else $error("cycle enable during halt"); // R5
  AST_HALT_WAKE: assert property (@(posedge clk_in) disable iff (por_flag)
    !sync_n |=> !halted_q) else $error("reset did not end halt"); // R5
  AST_ABORT_CAPTURE: assert property (@(posedge clk_in) disable iff (por_flag)
    (reset_entry && wr_busy) |=> abort_q) else $error("aborted write missed"); // R8
  AST_RELEASE_WINDOW: assert final (REL_LAT <= 2 * DIV)
    else $error("release later than two cycles"); // R3
endmodule

// File: tb/mcu_reset_ctrl_test.sv
module mcu_reset_ctrl_test;
  logic clk = 1'b0;
  logic rst_pin_n;
  logic por_flag, halt_req, wr_busy;
  logic cyc_en, core_run, halted, port_hiz, port_d_high;
  logic wr_abort, cold_rst, retained_ok;
  logic [7:0] sp_rst_val, ctrl_rst_val, uart_en_rst_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mcu_reset_ctrl uut (
    .clk_in(clk), .rst_pin_n(rst_pin_n), .por_flag(por_flag),
    .halt_req(halt_req), .wr_busy(wr_busy), .cyc_en(cyc_en),
    .core_run(core_run), .halted(halted), .port_hiz(port_hiz),
    .port_d_high(port_d_high), .wr_abort(wr_abort), .cold_rst(cold_rst),
    .retained_ok(retained_ok), .sp_rst_val(sp_rst_val),
    .ctrl_rst_val(ctrl_rst_val), .uart_en_rst_val(uart_en_rst_val)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  // Pin low at posedge+2; checks immediate forcing, then entry flags
  task automatic pull_low(input int len, input bit exp_abort);
    rst_pin_n = 1'b0;
    #1;
    chk(port_hiz == 1'b1, "R2 hiz", 32'(port_hiz), 1);
    chk(port_d_high == 1'b1, "R2 d_high", 32'(port_d_high), 1);
    chk(core_run == 1'b0, "R2 run", 32'(core_run), 0);
    #1;
    step(1);
    chk(wr_abort == exp_abort, "R8 abort", 32'(wr_abort), 32'(exp_abort));
    chk(cold_rst == por_flag, "R9 cold", 32'(cold_rst), 32'(por_flag));
    chk(retained_ok == (!por_flag && !exp_abort), "R9 retained",
        32'(retained_ok), 32'(!por_flag && !exp_abort));
    chk(halted == 1'b0, "R5 wake", 32'(halted), 0);
    wr_busy = 1'b0;
    step(len - 1);
    chk(cyc_en == 1'b0, "R1 held", 32'(cyc_en), 0);
  endtask

  // Release: cyc_en after edge 11, core_run after edge 12
  task automatic release_pin();
    rst_pin_n = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      step(1);
      chk(core_run == (k == 12), "R3 run timing", 32'(core_run), 32'(k == 12));
      chk(cyc_en == (k == 11), "R3 boundary", 32'(cyc_en), 32'(k == 11));
      chk(port_hiz == (k < 12) && port_d_high == (k < 12), "R6 ports",
          32'(port_hiz), 32'(k < 12));
    end
  endtask

  task automatic run_period(input int n);
    for (int k = 1; k <= n; k++) begin
      step(1);
      chk(cyc_en == ((k % 10) == 9), "R1 period", 32'(cyc_en), 32'((k % 10) == 9));
      chk(core_run == 1'b1, "R6 running", 32'(core_run), 1);
    end
  endtask

  initial begin
    rst_pin_n = 1'b0;
    por_flag  = 1'b1;
    halt_req  = 1'b0;
    wr_busy   = 1'b0;
    step(4);
    chk(core_run == 1'b0 && port_hiz == 1'b1, "R6 reset state", 32'(core_run), 0);
    chk(cold_rst == 1'b1 && retained_ok == 1'b0, "R9 cold start", 32'(cold_rst), 1);
    chk(wr_abort == 1'b0, "R9 abort cleared", 32'(wr_abort), 0);
    chk(sp_rst_val == 8'h6F, "R7 sp", 32'(sp_rst_val), 32'h6F);
    chk(ctrl_rst_val == 8'h00, "R7 ctrl", 32'(ctrl_rst_val), 0);
    chk(uart_en_rst_val == 8'h02, "R7 uart", 32'(uart_en_rst_val), 2);
    release_pin();
    por_flag = 1'b0;
    run_period(30);

    // R4: pin-fall phase sweep over all divider phases and lengths
    for (int ph = 0; ph < 10; ph++) begin
      step(ph);
      pull_low(10 + (ph % 4), 1'b0);
      release_pin();
      run_period(10);
    end

    // R5: halt then wake by reset
    step(9);
    chk(cyc_en == 1'b1, "R1 pre-halt", 32'(cyc_en), 1);
    halt_req = 1'b1;
    step(1);
    halt_req = 1'b0;
    chk(halted == 1'b1, "R5 halt entry", 32'(halted), 1);
    for (int k = 0; k < 30; k++) begin
      step(1);
      chk(cyc_en == 1'b0 && halted == 1'b1, "R5 halted quiet", 32'(cyc_en), 0);
    end
    pull_low(10, 1'b0);
    release_pin();
    run_period(10);

    // R8: write cut short by warm reset, flag held into next run
    wr_busy = 1'b1;
    pull_low(10, 1'b1);
    release_pin();
    chk(wr_abort == 1'b1 && retained_ok == 1'b0, "R8 abort held", 32'(wr_abort), 1);
    run_period(10);
    pull_low(12, 1'b0);
    release_pin();
    chk(retained_ok == 1'b1, "R9 warm ok", 32'(retained_ok), 1);

    // R9: cold reset clears abort even with write in progress
    wr_busy = 1'b1;
    por_flag = 1'b1;
    rst_pin_n = 1'b0;
    step(1);
    chk(wr_abort == 1'b0 && cold_rst == 1'b1, "R9 cold clears abort", 32'(wr_abort), 0);
    wr_busy = 1'b0;
    step(9);
    release_pin();
    por_flag = 1'b0;
    chk(retained_ok == 1'b0, "R9 cold retained", 32'(retained_ok), 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule